// File: doc/BRIEF.md
# Handshaked Serial Configuration Port

This block is the slave side of a configuration link that a host drives over two wires: a slow serial clock and a data line. The port also drives one response line back to the host, with an enable that marks when it does so. The host opens a session with a fixed four-step pattern on clock and data. The port answers each accepted step on the response line. An 8-bit command follows, then either a 72-bit configuration load from the host or a 72-bit readback to it.

The configuration holds a 32-bit station address, a 16-bit reporting interval, an 8-bit debounce time and a 16-bit counter preset. These registers stand in for the non-volatile store. They are exposed as outputs together with a one-cycle write strobe, so that a storage block can copy them. The host lines are sampled in the system clock domain through two-stage synchronisers. Both transfer directions move each byte most significant bit first. The byte order is: address (four bytes, most significant first), interval high, interval low, debounce, preset high, preset low.

Top module: `cfg_port`

## Requirements
- R1: After reset the address is 0, the interval is INTERVAL_RST (1), the debounce is DEBOUNCE_RST (50) and the preset is 0. The response enable and the write strobe are low.
- R2: The session opens with (host clock, host data) steps (0,1), (0,0), (0,1), (1,1), in that order. After the port accepts each step it drives the response enable high with response values 0, 1, 0, 1 respectively.
- R3: A step that is neither the expected next step nor the one still held from before returns the port to waiting for the first step, with the response enable low. A later step alone never opens a session.
- R4: After the fourth step, the next 8 host-data bits sampled on rising host-clock edges form the command, most significant bit first.
- R5: Command 0xA0 takes the next 72 bits, MSB first, as address[31:0], interval[15:0], debounce[7:0], preset[15:0]. Any preset from 0 to 65535 is accepted.
- R6: An accepted load updates all four registers in the same cycle, with a write strobe exactly one cycle wide. The registers never change at any other time.
- R7: A load whose interval is outside 1..INTERVAL_MAX (10000), or whose debounce is 0, is dropped: no strobe, and all old values are kept.
- R8: Command 0x05 keeps the response enable high and sends the 72 stored bits in the R5 order. Each bit changes after a falling host-clock edge, so the host reads it at the following rising edge.
- R9: Any other command ends the session with the response enable low. Bits that follow it never load the registers.
- R10: Every finished load or readback returns the port to waiting for the first handshake step, with the response enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_clk | input | 1 | Serial clock from the host (asynchronous) |
| host_dat | input | 1 | Serial data from the host (asynchronous) |
| resp_out | output | 1 | Response / readback bit toward the host |
| resp_en | output | 1 | High while the port drives the response line |
| wr_stb | output | 1 | One-cycle pulse when a load is committed |
| cfg_addr | output | 32 | Station address |
| cfg_interval | output | 16 | Reporting interval |
| cfg_debounce | output | 8 | Debounce time |
| cfg_preset | output | 16 | Counter preset |

## Verification
The bench builds the port with its default parameters: an interval ceiling of 10000, a reset interval of 1 and a reset debounce of 50. With these values, every boundary of the load acceptance rule (0, 1, 2, 9999, 10000, 10001, 65535 crossed with debounce 0, 1, 255) is covered by a load followed by a readback. All 256 command codes are swept after a handshake. Because 0xA0 and 0x05 are bit reverses of each other, a reversed command bit order shows up as swapped operations.

// File: rtl/cfg_port.sv
module cfg_port #(
  parameter int unsigned INTERVAL_MAX = 10000,
  parameter logic [15:0] INTERVAL_RST = 16'd1,
  parameter logic [7:0]  DEBOUNCE_RST = 8'd50
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_clk,
  input  logic        host_dat,
  output logic        resp_out,
  output logic        resp_en,
  output logic        wr_stb,
  output logic [31:0] cfg_addr,
  output logic [15:0] cfg_interval,
  output logic [7:0]  cfg_debounce,
  output logic [15:0] cfg_preset
);
  localparam int PW = 72;
  localparam int CW = $clog2(PW);
  localparam logic [7:0] OP_WR = 8'hA0;
  localparam logic [7:0] OP_RD = 8'h05;

  typedef enum logic [2:0] {S_HS0, S_HS1, S_HS2, S_HS3, S_CMD, S_WR, S_RD} st_t;
  st_t state;

  logic [2:0]    hc_q;
  logic [1:0]    hd_q;
  logic [PW-1:0] sh;
  logic [CW-1:0] cnt;

  wire [1:0] line = {hc_q[1], hd_q[1]};
  wire rise = hc_q[1] & ~hc_q[2];
  wire fall = ~hc_q[1] & hc_q[2];
  wire [PW-1:0] sh_in = {sh[PW-2:0], hd_q[1]};
  wire [1:0] hs_want = (state == S_HS1) ? 2'b00 : (state == S_HS3) ? 2'b11 : 2'b01;
  wire [1:0] hs_hold = (state == S_HS2) ? 2'b00 : 2'b01;
  wire ld_ok = (sh_in[39:24] != 16'd0) && (32'(sh_in[39:24]) <= INTERVAL_MAX) &&
               (sh_in[23:16] != 8'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hc_q <= '0;
      hd_q <= '0;
    end else begin
      hc_q <= {hc_q[1:0], host_clk};
      hd_q <= {hd_q[0], host_dat};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_HS0;
      sh           <= '0;
      cnt          <= '0;
      resp_out     <= 1'b0;
      resp_en      <= 1'b0;
      wr_stb       <= 1'b0;
      cfg_addr     <= '0;
      cfg_interval <= INTERVAL_RST;
      cfg_debounce <= DEBOUNCE_RST;
      cfg_preset   <= '0;
    end else begin
      wr_stb <= 1'b0;
      case (state)
        S_HS0: if (line == 2'b01) begin
          state    <= S_HS1;
          resp_out <= 1'b0;
          resp_en  <= 1'b1;
        end
        S_HS1, S_HS2, S_HS3: begin
          if (line == hs_want) begin
            resp_out <= (state != S_HS2);
            cnt      <= '0;
            state    <= (state == S_HS1) ? S_HS2 : (state == S_HS2) ? S_HS3 : S_CMD;
          end else if (line != hs_hold) begin
            state   <= S_HS0;
            resp_en <= 1'b0;
          end
        end
        S_CMD: if (rise) begin
          sh  <= sh_in;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(7)) begin
            cnt <= '0;
            if (sh_in[7:0] == OP_WR) begin
              state   <= S_WR;
              resp_en <= 1'b0;
            end else if (sh_in[7:0] == OP_RD) begin
              state <= S_RD;
              sh    <= {cfg_addr, cfg_interval, cfg_debounce, cfg_preset};
            end else begin
              state   <= S_HS0;
              resp_en <= 1'b0;
            end
          end
        end
        S_WR: if (rise) begin
          sh  <= sh_in;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(PW-1)) begin
            state <= S_HS0;
            if (ld_ok) begin
              wr_stb       <= 1'b1;
              cfg_addr     <= sh_in[71:40];
              cfg_interval <= sh_in[39:24];
              cfg_debounce <= sh_in[23:16];
              cfg_preset   <= sh_in[15:0];
            end
          end
        end
        S_RD: begin
          if (fall) begin
            resp_out <= sh[PW-1];
            sh       <= {sh[PW-2:0], 1'b0};
          end
          if (rise) begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(PW-1)) begin
              state   <= S_HS0;
              resp_en <= 1'b0;
            end
          end
        end
        default: state <= S_HS0;
      endcase
    end
  end

  AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R6
  AST_CFG_ONLY_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
    ({cfg_addr, cfg_interval, cfg_debounce, cfg_preset} !=
     $past({cfg_addr, cfg_interval, cfg_debounce, cfg_preset})) |-> wr_stb); // R6
  AST_INTERVAL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_interval != 16'd0) && (32'(cfg_interval) <= INTERVAL_MAX)); // R7
  AST_DEBOUNCE_NZ: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_debounce != 8'd0); // R7
  AST_STB_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(state) == S_WR); // R5
  AST_RD_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RD) |-> resp_en); // R8
  AST_RD_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RD && rise) |-> $stable(resp_out)); // R8
  AST_HS_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_HS1 || state == S_HS2 || state == S_HS3) && line != hs_want && line != hs_hold)
    |=> (state == S_HS0 && !resp_en)); // R3
endmodule

// File: tb/tb_cfg_port.sv
module tb_cfg_port;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_clk = 1'b0;
  logic host_dat = 1'b0;
  logic resp_out, resp_en, wr_stb;
  logic [31:0] cfg_addr;
  logic [15:0] cfg_interval, cfg_preset;
  logic [7:0]  cfg_debounce;

  int total = 0;
  int bad = 0;
  int stb_cnt = 0;
  bit done = 1'b0;

  logic [31:0] e_addr = 32'd0;
  logic [15:0] e_int = 16'd1;
  logic [7:0]  e_deb = 8'd50;
  logic [15:0] e_pre = 16'd0;

  cfg_port dut (
    .clk(clk), .rst_n(rst_n), .host_clk(host_clk), .host_dat(host_dat),
    .resp_out(resp_out), .resp_en(resp_en), .wr_stb(wr_stb),
    .cfg_addr(cfg_addr), .cfg_interval(cfg_interval),
    .cfg_debounce(cfg_debounce), .cfg_preset(cfg_preset)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n && wr_stb) stb_cnt <= stb_cnt + 1;

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host(input logic c, input logic d);
    @(negedge clk);
    host_clk = c;
    host_dat = d;
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic handshake();
    host(1'b0, 1'b1); chk("R2 step1", {resp_en, resp_out}, 2'b10);
    host(1'b0, 1'b0); chk("R2 step2", {resp_en, resp_out}, 2'b11);
    host(1'b0, 1'b1); chk("R2 step3", {resp_en, resp_out}, 2'b10);
    host(1'b1, 1'b1); chk("R2 step4", {resp_en, resp_out}, 2'b11);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      host(1'b0, b[i]);
      host(1'b1, b[i]);
    end
  endtask

  task automatic send72(input logic [71:0] v);
    for (int i = 71; i >= 0; i--) begin
      host(1'b0, v[i]);
      host(1'b1, v[i]);
    end
  endtask

  task automatic read_back(output logic [71:0] v, output logic en_ok);
    en_ok = 1'b1;
    for (int i = 71; i >= 0; i--) begin
      host(1'b0, 1'b0);
      v[i] = resp_out;
      if (resp_en !== 1'b1) en_ok = 1'b0;
      host(1'b1, 1'b0);
    end
  endtask

  task automatic load(input logic [31:0] a, input logic [15:0] iv,
                      input logic [7:0] db, input logic [15:0] pr);
    int s0;
    bit ok;
    s0 = stb_cnt;
    ok = (iv >= 16'd1) && (iv <= 16'd10000) && (db != 8'd0);
    handshake();
    send_byte(8'hA0);
    chk("R5 resp released during load", {71'd0, resp_en}, 72'd0);
    send72({a, iv, db, pr});
    host(1'b0, 1'b0);
    if (ok) begin
      e_addr = a; e_int = iv; e_deb = db; e_pre = pr;
    end
    chk(ok ? "R6 one strobe on accepted load" : "R7 no strobe on rejected load",
        72'(stb_cnt - s0), ok ? 72'd1 : 72'd0);
    chk(ok ? "R5 registers after load" : "R7 old values kept",
        {cfg_addr, cfg_interval, cfg_debounce, cfg_preset}, {e_addr, e_int, e_deb, e_pre});
    chk("R10 idle after load", {71'd0, resp_en}, 72'd0);
  endtask

  task automatic readout();
    logic [71:0] v;
    logic en_ok;
    handshake();
    send_byte(8'h05);
    read_back(v, en_ok);
    chk("R8 readback data", v, {e_addr, e_int, e_deb, e_pre});
    chk("R8 enable held during readback", {71'd0, en_ok}, 72'd1);
    host(1'b0, 1'b0);
    chk("R10 idle after readback", {71'd0, resp_en}, 72'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] ivs [7];
    logic [7:0]  dbs [3];
    int s0;
    ivs = '{16'd0, 16'd1, 16'd2, 16'd9999, 16'd10000, 16'd10001, 16'd65535};
    dbs = '{8'd0, 8'd1, 8'd255};

    repeat (4) @(negedge clk);
    chk("R1 reset state", {cfg_addr, cfg_interval, cfg_debounce, cfg_preset},
        {32'd0, 16'd1, 8'd50, 16'd0});
    chk("R1 outputs idle in reset", {70'd0, resp_en, wr_stb}, 72'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", {70'd0, resp_en, wr_stb}, 72'd0);

    readout();

    // R3: broken handshakes
    host(1'b0, 1'b1);
    host(1'b1, 1'b0);
    chk("R3 bad second step", {71'd0, resp_en}, 72'd0);
    host(1'b0, 1'b0);
    chk("R3 later step alone ignored", {71'd0, resp_en}, 72'd0);
    host(1'b0, 1'b1); host(1'b0, 1'b0); host(1'b0, 1'b1);
    host(1'b0, 1'b0);
    chk("R3 bad fourth step", {71'd0, resp_en}, 72'd0);
    host(1'b1, 1'b1);
    chk("R3 stays waiting", {71'd0, resp_en}, 72'd0);
    host(1'b0, 1'b0);

    // R5, R6, R7: acceptance sweep with readback
    for (int i = 0; i < 7; i++) begin
      for (int j = 0; j < 3; j++) begin
        load({8'(i), 8'(j), 8'hC3, 8'(i * 37 + j)}, ivs[i], dbs[j],
             (i == 3) ? 16'hFFFF : 16'(i * 4099 + j * 3));
        readout();
      end
    end

    // R4, R9: every command code
    s0 = stb_cnt;
    for (int c = 0; c < 256; c++) begin
      if (c != 8'hA0 && c != 8'h05) begin
        handshake();
        send_byte(8'(c));
        chk("R9 unknown command ends session", {71'd0, resp_en}, 72'd0);
        host(1'b0, 1'b0);
      end
    end
    chk("R4 no strobe across command sweep", 72'(stb_cnt - s0), 72'd0);

    // R9: trailing bits after unknown commands never load
    for (int k = 0; k < 4; k++) begin
      s0 = stb_cnt;
      handshake();
      send_byte((k == 0) ? 8'hA1 : (k == 1) ? 8'h20 : (k == 2) ? 8'h04 : 8'h07);
      send72({32'h1234_5678, 16'd100, 8'd9, 16'd77});
      host(1'b0, 1'b0);
      chk("R9 trailing bits ignored", 72'(stb_cnt - s0), 72'd0);
    end
    readout();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule